// File: doc/BRIEF.md
# Multi-Mode Compare/Capture Channel

This block is one 16-bit event channel that sits beside a free-running period counter. The counter, its period register and its prescaler live outside the block. The channel receives the current count and the period as inputs. A two-bit mode input decides what the channel's event value means.

- **Timer mode:** the value is a compare point that raises a sticky event flag.
- **Capture mode:** the value is loaded from the counter on an external trigger pulse.
- **First PWM mode:** the value sets the duty of a pair of complementary PWM outputs.
- **Second PWM mode:** the channel raises no event at all.

Software reaches the value through a small register port. It has a write strobe, a read strobe, 16-bit write data and an always-valid read data bus. Whether a write is accepted depends on the mode. In capture mode, a read also clears the event flag. The interrupt output is the flag gated by an enable input. A status output reports a timer compare value that can never be reached within the period.

Top module: `evt_channel`

## Requirements
- R1: After reset the event value reads 0000H, and the event flag, the interrupt, both PWM outputs and the status output are all 0.
- R2: A write strobe in timer mode (mode 0), first PWM mode (mode 2) or second PWM mode (mode 3) loads the write data into the event value. The new value appears on the read bus after the next clock edge.
- R3: In timer mode, with a valid compare value V, the event flag becomes 1 at the edge where the count input equals V+1. The flag stays set until the clear input is asserted.
- R4: In capture mode (mode 1), a trigger pulse loads the count input into the event value and sets the event flag. Bus writes in capture mode leave the event value unchanged.
- R5: In capture mode a read strobe clears the event flag. If a trigger arrives in the same cycle as the read, the flag ends up set and the new value is held.
- R6: In first PWM mode the non-inverted output is 1 exactly while the count is below the event value, and the inverted output is its complement. In every other mode both PWM outputs are 0.
- R7: In second PWM mode no count value and no trigger pulse sets the event flag.
- R8: In timer mode the status output is 1 whenever the event value is not below the period. While it is 1, no compare event sets the flag.
- R9: The interrupt output equals the event flag ANDed with the interrupt enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 timer, 1 capture, 2 first PWM, 3 second PWM |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Current event value |
| count | input | 16 | Current value of the external counter |
| period | input | 16 | External period value |
| cap_trig | input | 1 | Single-cycle capture trigger |
| ev_ien | input | 1 | Event interrupt enable |
| ev_clr | input | 1 | Event flag clear |
| ev_flag | output | 1 | Sticky event flag |
| ev_irq | output | 1 | Event interrupt |
| pwm_p | output | 1 | Non-inverted PWM output |
| pwm_n | output | 1 | Inverted PWM output |
| cmp_bad | output | 1 | Timer compare value not below period |

## Verification
The assertions assume the following about the inputs:

- The capture trigger is a single-cycle pulse.
- The mode is settled before any register access that relies on it.
- The clear input and the capture-mode read are the only ways the flag falls.

The stimulus changes the mode only on cycles that carry no write. It drives each trigger high for exactly one clock. It steps the count directly to the values around each compare point, so the flag's rising edge lands where the properties expect it.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [1:0] {
    MD_TIMER = 2'd0,
    MD_CAPT  = 2'd1,
    MD_PWM1  = 2'd2,
    MD_PWM2  = 2'd3
  } evt_mode_e;
endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/evt_reg.sv
module evt_reg
  import evt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  evt_mode_e    mode,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         cap_trig,
  input  logic [W-1:0] count,
  output logic [W-1:0] q
);
  logic [W-1:0] val_q;
  logic [W-1:0] val_d;
  logic         val_en;
  logic         cap_take;
  logic         wr_take;

  always_comb begin
    cap_take = (mode == MD_CAPT) && cap_trig;
    wr_take  = (mode != MD_CAPT) && wr_en;
    val_en   = cap_take || wr_take;
    val_d    = cap_take ? count : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_d;
  end

  assign q = val_q;

  // R4: a capture-mode write without a trigger keeps the held value
  p_capt_wr_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_CAPT && wr_en && !cap_trig) |=> (q == $past(q)));

  // R2: an accepted write lands in the value
  p_wr_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_CAPT && wr_en) |=> (q == $past(wdata)));
endmodule

// File: rtl/evt_cmp.sv
module evt_cmp
  import evt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  evt_mode_e    mode,
  input  logic [W-1:0] q,
  input  logic [W-1:0] count,
  input  logic [W-1:0] period,
  output logic         hit,
  output logic         bad
);
  localparam int unsigned WE = W + 1;

  logic [WE-1:0] target;
  logic          in_timer;

  always_comb begin
    in_timer = (mode == MD_TIMER);
    target   = {1'b0, q} + WE'(1);
    bad      = in_timer && (q >= period);
    hit      = in_timer && !bad && ({1'b0, count} == target);
  end
endmodule

// File: rtl/evt_flag.sv
module evt_flag
  import evt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  evt_mode_e mode,
  input  logic      hit,
  input  logic      bad,
  input  logic      cap_trig,
  input  logic      rd_en,
  input  logic      clr,
  input  logic      ien,
  output logic      flag,
  output logic      irq
);
  logic flag_q;
  logic flag_d;
  logic set_ev;
  logic clr_ev;

  always_comb begin
    set_ev = hit || ((mode == MD_CAPT) && cap_trig);
    clr_ev = clr || ((mode == MD_CAPT) && rd_en);
    if (set_ev)      flag_d = 1'b1;
    else if (clr_ev) flag_d = 1'b0;
    else             flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign irq  = flag_q && ien;

  // R5: capture-mode read with no trigger clears the flag
  p_rd_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_CAPT && rd_en && !cap_trig) |=> !flag);

  // R3: a compare hit sets the flag
  p_hit_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  // R7: second PWM mode never raises the flag
  p_pwm2_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PWM2 && !flag) |=> !flag);

  // R8: an unreachable compare value never raises the flag
  p_nobad_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_TIMER && bad && !flag) |=> !flag);
endmodule

// File: rtl/evt_pwm.sv
module evt_pwm
  import evt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  evt_mode_e    mode,
  input  logic [W-1:0] q,
  input  logic [W-1:0] count,
  output logic         pwm_p,
  output logic         pwm_n
);
  logic active;
  logic below;

  always_comb begin
    active = (mode == MD_PWM1);
    below  = (count < q);
    pwm_p  = active && below;
    pwm_n  = active && !below;
  end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] count,
  input  logic [W-1:0] period,
  input  logic         cap_trig,
  input  logic         ev_ien,
  input  logic         ev_clr,
  output logic         ev_flag,
  output logic         ev_irq,
  output logic         pwm_p,
  output logic         pwm_n,
  output logic         cmp_bad
);
  evt_mode_e    md;
  logic         srst_n;
  logic [W-1:0] val;
  logic         hit;
  logic         bad;

  assign md = evt_mode_e'(mode);

  evt_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  evt_reg #(.W(W)) u_reg (
    .clk(clk), .rst_n(srst_n), .mode(md), .wr_en(wr_en), .wdata(wdata),
    .cap_trig(cap_trig), .count(count), .q(val)
  );

  evt_cmp #(.W(W)) u_cmp (
    .mode(md), .q(val), .count(count), .period(period), .hit(hit), .bad(bad)
  );

  evt_flag u_flag (
    .clk(clk), .rst_n(srst_n), .mode(md), .hit(hit), .bad(bad),
    .cap_trig(cap_trig), .rd_en(rd_en), .clr(ev_clr), .ien(ev_ien),
    .flag(ev_flag), .irq(ev_irq)
  );

  evt_pwm #(.W(W)) u_pwm (
    .mode(md), .q(val), .count(count), .pwm_p(pwm_p), .pwm_n(pwm_n)
  );

  assign rdata   = val;
  assign cmp_bad = bad;

  // R9: interrupt follows flag and enable
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!srst_n)
    ev_irq == (ev_flag && ev_ien));

  // R6: first PWM mode drives exactly one of the pair
  p_pwm_pair_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (md == MD_PWM1) |-> $countones({pwm_p, pwm_n}) == 1);
endmodule

// File: tb/evt_channel_test.sv
module evt_channel_test;
  typedef struct {
    logic        flag;
    logic        irq;
    logic [15:0] rdata;
    logic        pp;
    logic        pn;
    logic        bad;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        wr_en, rd_en, cap_trig, ev_ien, ev_clr;
  logic [15:0] wdata, count, period;
  logic [15:0] rdata;
  logic        ev_flag, ev_irq, pwm_p, pwm_n, cmp_bad;

  int   total = 0;
  int   bad_n = 0;
  bit   done  = 0;
  exp_t sb[$];

  logic [15:0] m_val  = '0;
  logic        m_flag = 1'b0;

  always #10 clk = ~clk;

  evt_channel uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .count(count), .period(period),
    .cap_trig(cap_trig), .ev_ien(ev_ien), .ev_clr(ev_clr),
    .ev_flag(ev_flag), .ev_irq(ev_irq), .pwm_p(pwm_p), .pwm_n(pwm_n),
    .cmp_bad(cmp_bad)
  );

  task automatic step(input logic [1:0] md, input logic wr, input logic rd,
                      input logic [15:0] wd, input logic [15:0] cnt,
                      input logic [15:0] per, input logic trg, input logic ien,
                      input logic clr, input string req);
    logic [15:0] nval;
    logic        nflag;
    logic        set_e, clr_e;
    exp_t        e;
    @(negedge clk);
    mode = md; wr_en = wr; rd_en = rd; wdata = wd; count = cnt;
    period = per; cap_trig = trg; ev_ien = ien; ev_clr = clr;
    nval = m_val;
    if (wr && md != 2'd1) nval = wd;
    if (trg && md == 2'd1) nval = cnt;
    set_e = (md == 2'd1 && trg) ||
            (md == 2'd0 && m_val < per && {1'b0, cnt} == {1'b0, m_val} + 17'd1);
    clr_e = clr || (md == 2'd1 && rd);
    nflag = set_e ? 1'b1 : (clr_e ? 1'b0 : m_flag);
    m_val = nval; m_flag = nflag;
    e.flag  = nflag;
    e.irq   = nflag & ien;
    e.rdata = nval;
    e.pp    = (md == 2'd2) && (cnt < nval);
    e.pn    = (md == 2'd2) && !(cnt < nval);
    e.bad   = (md == 2'd0) && (nval >= per);
    e.req   = req;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (ev_flag !== e.flag || ev_irq !== e.irq || rdata !== e.rdata ||
          pwm_p !== e.pp || pwm_n !== e.pn || cmp_bad !== e.bad) begin
        bad_n++;
        $display("FAIL %s: got flag=%b irq=%b rdata=%h p=%b n=%b bad=%b exp flag=%b irq=%b rdata=%h p=%b n=%b bad=%b",
                 e.req, ev_flag, ev_irq, rdata, pwm_p, pwm_n, cmp_bad,
                 e.flag, e.irq, e.rdata, e.pp, e.pn, e.bad);
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad_n++;
      $display("FAIL watchdog: got hung exp finished");
      $display("test done: total=%0d bad=%0d", total, bad_n);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'd0; wr_en = 0; rd_en = 0; wdata = '0; count = '0;
    period = 16'd100; cap_trig = 0; ev_ien = 0; ev_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    step(2'd0, 0, 0, 16'h0, 16'd0, 16'd100, 0, 0, 0, "R1");
    // R2 write in timer mode
    step(2'd0, 1, 0, 16'd5, 16'd0, 16'd100, 0, 0, 0, "R2");
    // R3 compare at value+1
    step(2'd0, 0, 0, 16'h0, 16'd5, 16'd100, 0, 1, 0, "R3");
    step(2'd0, 0, 0, 16'h0, 16'd6, 16'd100, 0, 1, 0, "R3");
    step(2'd0, 0, 0, 16'h0, 16'd7, 16'd100, 0, 1, 0, "R3");
    // R9 enable gating
    step(2'd0, 0, 0, 16'h0, 16'd8, 16'd100, 0, 0, 0, "R9");
    step(2'd0, 0, 0, 16'h0, 16'd9, 16'd100, 0, 0, 1, "R3");
    // R8 value not below period
    step(2'd0, 1, 0, 16'd100, 16'd0, 16'd100, 0, 1, 0, "R8");
    step(2'd0, 0, 0, 16'h0, 16'd101, 16'd100, 0, 1, 0, "R8");
    step(2'd0, 0, 0, 16'h0, 16'd101, 16'd101, 0, 1, 0, "R8");
    step(2'd0, 0, 0, 16'h0, 16'd0, 16'd101, 0, 1, 1, "R3");
    // R4 capture
    step(2'd1, 0, 0, 16'h0, 16'h1234, 16'd100, 1, 1, 0, "R4");
    step(2'd1, 1, 0, 16'hBEEF, 16'h1300, 16'd100, 0, 1, 0, "R4");
    // R5 read clears, trigger wins
    step(2'd1, 0, 1, 16'h0, 16'h1301, 16'd100, 0, 1, 0, "R5");
    step(2'd1, 0, 1, 16'h0, 16'h0042, 16'd100, 1, 1, 0, "R5");
    step(2'd1, 0, 1, 16'h0, 16'h0043, 16'd100, 0, 1, 0, "R5");
    // R6 PWM1
    step(2'd2, 1, 0, 16'd10, 16'd3, 16'd100, 0, 0, 0, "R6");
    step(2'd2, 0, 0, 16'h0, 16'd9, 16'd100, 0, 0, 0, "R6");
    step(2'd2, 0, 0, 16'h0, 16'd10, 16'd100, 0, 0, 0, "R6");
    step(2'd2, 0, 0, 16'h0, 16'd11, 16'd100, 0, 0, 0, "R6");
    step(2'd2, 1, 0, 16'h0, 16'd0, 16'd100, 0, 0, 0, "R6");
    step(2'd2, 1, 0, 16'hFFFF, 16'hFFFE, 16'd100, 0, 0, 0, "R6");
    // R7 PWM2 quiet
    step(2'd3, 1, 0, 16'd3, 16'd0, 16'd100, 0, 1, 0, "R7");
    step(2'd3, 0, 0, 16'h0, 16'd4, 16'd100, 0, 1, 0, "R7");
    step(2'd3, 0, 0, 16'h0, 16'd5, 16'd100, 1, 1, 0, "R7");
    step(2'd3, 0, 1, 16'h0, 16'd6, 16'd100, 0, 1, 0, "R7");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad_n);
    $finish;
  end
endmodule